// File: doc/BRIEF.md
# Bus Master Sequencer

This block places three internal requesters of a small processor (instruction fetch, data load and data store) on a single Wishbone classic master port. A state machine grants one request at a time. It drives the bus cycle until the slave answers, and then hands read data, a ready pulse or an error flag back to the requester that owned the cycle. The state machine also produces the reset for the processor core. The core leaves reset one clock after the external reset is removed.

Each requester raises its request as a level and holds it until it sees either its ready pulse or its error flag. The address, write data and byte enables are captured when the request is granted, so they stay fixed for the whole bus cycle. The requester that caused a bus error is recorded when the error response arrives. An optional response timeout turns a silent slave into an ordinary bus error.

Top module: `bus_master_top`

## Requirements
- R1: While rstIn is high at a rising edge, the next cycle shows coreRst=1, cycO=0, stbO=0, selO all ones and no ready or error output set.
- R2: coreRst stays high through the first rising edge that samples rstIn low and is low from the following cycle on, until rstIn rises again.
- R3: A request seen in the idle state starts a bus cycle in the next clock. In that cycle cycO=stbO=1 and adrO carries the requester's address. weO=1 only for a store, and for a store datO carries storeData.
- R4: When requests are pending together in the idle state, the store is granted first, then the load, then the fetch.
- R5: Without ackI or errI (and before any timeout), cycO, stbO, weO and adrO hold their values from one cycle to the next.
- R6: In a cycle with ackI=1 and errI=0, the owning requester gets a one-cycle ready pulse with its read data equal to datI in that same cycle. cycO is low in the next cycle.
- R7: selO equals the captured storeBe while a store cycle is on the bus, and is all ones in every other cycle, including when cycO=0.
- R8: errI ends the bus cycle. For exactly one following cycle, only the error flag of the requester that owned the cycle is high and cycO=0. The owner is recorded when errI arrives, so request changes after that point do not affect it.
- R9: If errI and ackI arrive in the same cycle, the error path is taken and no ready pulse is given.
- R10: With the timeout enabled, a bus cycle that sees no response for TIMEOUT_CYCLES clocks (default 16) ends as in R8, with the owner's error flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstIn | input | 1 | External synchronous reset, active high |
| coreRst | output | 1 | Reset for the processor core |
| fetchReq | input | 1 | Instruction fetch request (level) |
| fetchAddr | input | ADDR_W | Fetch address |
| fetchReady | output | 1 | Fetch completed, data valid |
| fetchData | output | DATA_W | Fetched word |
| fetchErr | output | 1 | Fetch ended in a bus error |
| loadReq | input | 1 | Data load request (level) |
| loadAddr | input | ADDR_W | Load address |
| loadReady | output | 1 | Load completed, data valid |
| loadData | output | DATA_W | Loaded word |
| loadErr | output | 1 | Load ended in a bus error |
| storeReq | input | 1 | Data store request (level) |
| storeAddr | input | ADDR_W | Store address |
| storeData | input | DATA_W | Store data |
| storeBe | input | DATA_W/8 | Store byte enables |
| storeReady | output | 1 | Store completed |
| storeErr | output | 1 | Store ended in a bus error |
| cycO | output | 1 | Bus cycle active |
| stbO | output | 1 | Bus strobe |
| weO | output | 1 | Bus write enable |
| adrO | output | ADDR_W | Bus address |
| datO | output | DATA_W | Bus write data |
| selO | output | DATA_W/8 | Bus byte select |
| datI | input | DATA_W | Bus read data |
| ackI | input | 1 | Slave acknowledge |
| errI | input | 1 | Slave error |

## Verification
Some properties are checked on every cycle by the embedded assertions: the single-cycle release of core reset, stable bus outputs while a cycle waits, the all-ones select outside store cycles, store-first grant order, ready pulses that occur only with an acknowledge, and the one-hot error flags that follow an error or a timeout. Other behaviour can only be shown by the directed scenarios. These are the exact reset values, the returned read data, the full store-load-fetch sequence when all three requests arrive together, correct error attribution while the requests change under it, error winning over a simultaneous acknowledge, and the exact length of the timeout window.

// File: rtl/bus_master_pkg.sv
package bus_master_pkg;

  typedef enum logic [2:0] {
    ST_START, ST_IDLE, ST_FETCH, ST_LOAD, ST_STORE, ST_ERROR
  } busState_t;

  typedef enum logic [1:0] {
    SRC_FETCH, SRC_LOAD, SRC_STORE
  } reqSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;   // latch request fields at grant
    reqSrc_t kind;      // which requester is granted
    logic    cntStep;   // a bus cycle is waiting for a response
    logic    writing;   // a store cycle is on the bus
  } dpStrobes_t;

endpackage

// File: rtl/bus_master_dp.sv
module bus_master_dp
  import bus_master_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter bit TIMEOUT_EN     = 1'b1,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstIn,
  input  dpStrobes_t          strobes,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W/8-1:0] storeBe,
  output logic [ADDR_W-1:0]   adrO,
  output logic [DATA_W-1:0]   datO,
  output logic [DATA_W/8-1:0] selO,
  output logic                timeoutHit
);

  localparam int SEL_W = DATA_W / 8;

  logic [ADDR_W-1:0] adrReg;
  logic [DATA_W-1:0] datReg;
  logic [SEL_W-1:0]  beReg;

  always_ff @(posedge clk) begin
    if (rstIn) begin
      adrReg <= '0;
      datReg <= '0;
      beReg  <= '1;
    end else if (strobes.capture) begin
      unique case (strobes.kind)
        SRC_STORE: adrReg <= storeAddr;
        SRC_LOAD:  adrReg <= loadAddr;
        default:   adrReg <= fetchAddr;
      endcase
      datReg <= storeData;
      beReg  <= (strobes.kind == SRC_STORE) ? storeBe : '1;
    end
  end

  assign adrO = adrReg;
  assign datO = datReg;
  assign selO = strobes.writing ? beReg : '1;

  generate
    if (TIMEOUT_EN) begin : g_timeout
      localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
      localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);
      logic [CW-1:0] waitCnt;

      always_ff @(posedge clk) begin
        if (rstIn || strobes.capture) waitCnt <= '0;
        else if (strobes.cntStep)     waitCnt <= waitCnt + 1'b1;
      end

      assign timeoutHit = strobes.cntStep && (waitCnt == LAST);
    end else begin : g_noTimeout
      assign timeoutHit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bus_master_ctrl.sv
module bus_master_ctrl
  import bus_master_pkg::*;
(
  input  logic       clk,
  input  logic       rstIn,
  input  logic       fetchReq,
  input  logic       loadReq,
  input  logic       storeReq,
  input  logic       ackI,
  input  logic       errI,
  input  logic       timeoutHit,
  output dpStrobes_t strobes,
  output logic       coreRst,
  output logic       cycO,
  output logic       stbO,
  output logic       weO,
  output logic       fetchReady,
  output logic       loadReady,
  output logic       storeReady,
  output logic       fetchErr,
  output logic       loadErr,
  output logic       storeErr
);

  busState_t state, nextState;
  reqSrc_t   errSrc, curSrc;
  logic      inXfer, respOk, goError;

  assign inXfer  = (state == ST_FETCH) || (state == ST_LOAD) || (state == ST_STORE);
  assign respOk  = inXfer && ackI && !errI;
  assign goError = inXfer && (errI || (!ackI && timeoutHit));

  always_comb begin
    unique case (state)
      ST_STORE: curSrc = SRC_STORE;
      ST_LOAD:  curSrc = SRC_LOAD;
      default:  curSrc = SRC_FETCH;
    endcase
  end

  always_comb begin
    nextState       = state;
    strobes.capture = 1'b0;
    strobes.kind    = SRC_FETCH;
    strobes.cntStep = inXfer;
    strobes.writing = (state == ST_STORE);
    unique case (state)
      ST_START: nextState = ST_IDLE;
      ST_IDLE: begin
        if (storeReq) begin
          nextState = ST_STORE; strobes.capture = 1'b1; strobes.kind = SRC_STORE;
        end else if (loadReq) begin
          nextState = ST_LOAD;  strobes.capture = 1'b1; strobes.kind = SRC_LOAD;
        end else if (fetchReq) begin
          nextState = ST_FETCH; strobes.capture = 1'b1; strobes.kind = SRC_FETCH;
        end
      end
      ST_FETCH, ST_LOAD, ST_STORE: begin
        if (goError)    nextState = ST_ERROR;
        else if (ackI)  nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstIn) begin
      state  <= ST_START;
      errSrc <= SRC_FETCH;
    end else begin
      state <= nextState;
      if (goError) errSrc <= curSrc;
    end
  end

  assign coreRst    = (state == ST_START);
  assign cycO       = inXfer;
  assign stbO       = inXfer;
  assign weO        = (state == ST_STORE);
  assign fetchReady = respOk && (state == ST_FETCH);
  assign loadReady  = respOk && (state == ST_LOAD);
  assign storeReady = respOk && (state == ST_STORE);
  assign fetchErr   = (state == ST_ERROR) && (errSrc == SRC_FETCH);
  assign loadErr    = (state == ST_ERROR) && (errSrc == SRC_LOAD);
  assign storeErr   = (state == ST_ERROR) && (errSrc == SRC_STORE);

  // core reset is released after exactly one cycle out of external reset
  assert_reset_release_R2: assert property (@(posedge clk) disable iff (rstIn)
    coreRst |=> !coreRst);

  // store wins over other pending requests
  assert_store_first_R4: assert property (@(posedge clk) disable iff (rstIn)
    (state == ST_IDLE && storeReq) |=> (cycO && weO));

  // ready only alongside an acknowledge, at most one, and the cycle then ends
  assert_ready_with_ack_R6: assert property (@(posedge clk) disable iff (rstIn)
    (fetchReady || loadReady || storeReady) |-> (ackI && $onehot0({fetchReady, loadReady, storeReady})));
  assert_ready_ends_cycle_R6: assert property (@(posedge clk) disable iff (rstIn)
    (fetchReady || loadReady || storeReady) |=> !cycO);

  // error goes to the owner of the cycle, one flag at most, bus idle
  assert_err_owner_R8: assert property (@(posedge clk) disable iff (rstIn)
    (cycO && weO && errI) |=> (storeErr && !loadErr && !fetchErr && !cycO));
  assert_err_onehot_R8: assert property (@(posedge clk) disable iff (rstIn)
    $onehot0({fetchErr, loadErr, storeErr}));
  assert_err_single_R8: assert property (@(posedge clk) disable iff (rstIn)
    (fetchErr || loadErr || storeErr) |=> !(fetchErr || loadErr || storeErr));

  // error beats acknowledge
  assert_err_over_ack_R9: assert property (@(posedge clk) disable iff (rstIn)
    (cycO && errI) |-> !(fetchReady || loadReady || storeReady));

  // timeout ends a silent cycle with an error
  assert_timeout_err_R10: assert property (@(posedge clk) disable iff (rstIn)
    (cycO && !ackI && !errI && timeoutHit) |=> (fetchErr || loadErr || storeErr));

endmodule

// File: rtl/bus_master_top.sv
module bus_master_top
  import bus_master_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter bit TIMEOUT_EN     = 1'b1,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstIn,
  output logic                coreRst,
  input  logic                fetchReq,
  input  logic [ADDR_W-1:0]   fetchAddr,
  output logic                fetchReady,
  output logic [DATA_W-1:0]   fetchData,
  output logic                fetchErr,
  input  logic                loadReq,
  input  logic [ADDR_W-1:0]   loadAddr,
  output logic                loadReady,
  output logic [DATA_W-1:0]   loadData,
  output logic                loadErr,
  input  logic                storeReq,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W/8-1:0] storeBe,
  output logic                storeReady,
  output logic                storeErr,
  output logic                cycO,
  output logic                stbO,
  output logic                weO,
  output logic [ADDR_W-1:0]   adrO,
  output logic [DATA_W-1:0]   datO,
  output logic [DATA_W/8-1:0] selO,
  input  logic [DATA_W-1:0]   datI,
  input  logic                ackI,
  input  logic                errI
);

  dpStrobes_t strobes;
  logic       timeoutHit;

  bus_master_ctrl u_ctrl (
    .clk(clk), .rstIn(rstIn),
    .fetchReq(fetchReq), .loadReq(loadReq), .storeReq(storeReq),
    .ackI(ackI), .errI(errI), .timeoutHit(timeoutHit),
    .strobes(strobes), .coreRst(coreRst),
    .cycO(cycO), .stbO(stbO), .weO(weO),
    .fetchReady(fetchReady), .loadReady(loadReady), .storeReady(storeReady),
    .fetchErr(fetchErr), .loadErr(loadErr), .storeErr(storeErr)
  );

  bus_master_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TIMEOUT_EN(TIMEOUT_EN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk(clk), .rstIn(rstIn), .strobes(strobes),
    .fetchAddr(fetchAddr), .loadAddr(loadAddr), .storeAddr(storeAddr),
    .storeData(storeData), .storeBe(storeBe),
    .adrO(adrO), .datO(datO), .selO(selO), .timeoutHit(timeoutHit)
  );

  assign fetchData = datI;
  assign loadData  = datI;

  // a waiting cycle keeps its bus outputs still
  assert_hold_bus_R5: assert property (@(posedge clk) disable iff (rstIn)
    (cycO && !ackI && !errI && !timeoutHit) |=> (cycO && stbO && $stable(weO) && $stable(adrO)));

  // select is all ones whenever no write is on the bus
  assert_sel_ones_R7: assert property (@(posedge clk) disable iff (rstIn)
    !weO |-> (&selO));

endmodule

// File: tb/sim_bus_master_top.sv
module sim_bus_master_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic fetchReq = 0, loadReq = 0, storeReq = 0;
  logic [AW-1:0] fetchAddr = '0, loadAddr = '0, storeAddr = '0;
  logic [DW-1:0] storeData = '0, datI = '0;
  logic [3:0] storeBe = '0;
  logic ackI = 0, errI = 0;
  logic coreRst, fetchReady, fetchErr, loadReady, loadErr, storeReady, storeErr;
  logic cycO, stbO, weO;
  logic [DW-1:0] fetchData, loadData, datO;
  logic [AW-1:0] adrO;
  logic [3:0] selO;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_master_top #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_EN(1'b1), .TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rstIn(rstIn), .coreRst(coreRst),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchReady(fetchReady),
    .fetchData(fetchData), .fetchErr(fetchErr),
    .loadReq(loadReq), .loadAddr(loadAddr), .loadReady(loadReady),
    .loadData(loadData), .loadErr(loadErr),
    .storeReq(storeReq), .storeAddr(storeAddr), .storeData(storeData),
    .storeBe(storeBe), .storeReady(storeReady), .storeErr(storeErr),
    .cycO(cycO), .stbO(stbO), .weO(weO), .adrO(adrO), .datO(datO), .selO(selO),
    .datI(datI), .ackI(ackI), .errI(errI)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [2:0] errs();
    return {storeErr, loadErr, fetchErr};
  endfunction

  task automatic t_reset();
    rstIn = 1'b1;
    repeat (3) @(negedge clk);
    chk(coreRst == 1, "R1 coreRst", coreRst, 1);
    chk(cycO == 0 && stbO == 0, "R1 cyc/stb", {cycO, stbO}, 0);
    chk(selO == 4'hF, "R1 sel", selO, 4'hF);
    chk(errs() == 0 && !fetchReady && !loadReady && !storeReady, "R1 flags", errs(), 0);
    rstIn = 1'b0;
    #1 chk(coreRst == 1, "R2 coreRst before edge", coreRst, 1);
    @(negedge clk);
    chk(coreRst == 0, "R2 coreRst released", coreRst, 0);
    repeat (2) @(negedge clk);
    chk(coreRst == 0, "R2 coreRst stays low", coreRst, 0);
  endtask

  task automatic t_fetch();
    fetchAddr = 32'h0000_1000; fetchReq = 1;
    @(negedge clk);
    chk(cycO && stbO && !weO, "R3 fetch cycle", {cycO, stbO, weO}, 3'b110);
    chk(adrO == 32'h1000, "R3 fetch addr", adrO, 32'h1000);
    chk(selO == 4'hF, "R7 sel on read", selO, 4'hF);
    datI = 32'hCAFE_0001; ackI = 1;
    #1 chk(fetchReady && !loadReady && fetchData == 32'hCAFE_0001, "R6 fetch ready/data", fetchData, 32'hCAFE_0001);
    @(negedge clk);
    ackI = 0; fetchReq = 0;
    chk(!cycO && !fetchReady, "R6 cycle ends", cycO, 0);
    @(negedge clk);
  endtask

  task automatic t_load_wait();
    loadAddr = 32'h0000_2004; loadReq = 1;
    @(negedge clk);
    loadAddr = 32'hFFFF_FFF0;
    repeat (3) begin
      chk(cycO && stbO && !weO && adrO == 32'h2004, "R5 hold during wait", adrO, 32'h2004);
      @(negedge clk);
    end
    datI = 32'h1234_5678; ackI = 1;
    #1 chk(loadReady && loadData == 32'h1234_5678, "R6 load data", loadData, 32'h1234_5678);
    @(negedge clk);
    ackI = 0; loadReq = 0;
    @(negedge clk);
  endtask

  task automatic t_store();
    storeAddr = 32'h0000_3008; storeData = 32'hA5A5_5A5A; storeBe = 4'b0110; storeReq = 1;
    @(negedge clk);
    chk(cycO && weO, "R3 store write", {cycO, weO}, 2'b11);
    chk(datO == 32'hA5A5_5A5A && adrO == 32'h3008, "R3 store data", datO, 32'hA5A5_5A5A);
    chk(selO == 4'b0110, "R7 sel store", selO, 4'b0110);
    ackI = 1;
    #1 chk(storeReady, "R6 store ready", storeReady, 1);
    @(negedge clk);
    ackI = 0; storeReq = 0;
    chk(selO == 4'hF && !cycO, "R7 sel after store", selO, 4'hF);
    @(negedge clk);
  endtask

  task automatic t_priority();
    fetchAddr = 32'h100; loadAddr = 32'h200; storeAddr = 32'h300;
    storeBe = 4'hF; fetchReq = 1; loadReq = 1; storeReq = 1;
    @(negedge clk);
    chk(weO && adrO == 32'h300, "R4 store first", adrO, 32'h300);
    ackI = 1; @(negedge clk); ackI = 0; storeReq = 0;
    @(negedge clk);
    chk(cycO && !weO && adrO == 32'h200, "R4 load second", adrO, 32'h200);
    ackI = 1; @(negedge clk); ackI = 0; loadReq = 0;
    @(negedge clk);
    chk(cycO && adrO == 32'h100, "R4 fetch last", adrO, 32'h100);
    ackI = 1; @(negedge clk); ackI = 0; fetchReq = 0;
    @(negedge clk);
  endtask

  task automatic t_error_attrib();
    storeAddr = 32'h400; storeReq = 1;
    @(negedge clk);
    errI = 1; storeReq = 0; loadReq = 1;
    #1 chk(!storeReady, "R8 no ready on err", storeReady, 0);
    @(negedge clk);
    errI = 0;
    chk(errs() == 3'b100 && !cycO, "R8 store error owner", errs(), 3'b100);
    @(negedge clk);
    loadReq = 0;
    chk(errs() == 0 && !cycO, "R8 error one cycle", errs(), 0);
    @(negedge clk);
  endtask

  task automatic t_err_and_ack();
    loadAddr = 32'h500; loadReq = 1;
    @(negedge clk);
    ackI = 1; errI = 1;
    #1 chk(!loadReady, "R9 no ready", loadReady, 0);
    @(negedge clk);
    ackI = 0; errI = 0; loadReq = 0;
    chk(errs() == 3'b010, "R9 error taken", errs(), 3'b010);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    int n = 0;
    fetchAddr = 32'h600; fetchReq = 1;
    @(negedge clk);
    while (cycO && n < 100) begin
      n++;
      @(negedge clk);
    end
    fetchReq = 0;
    chk(n == TO, "R10 timeout length", n, TO);
    chk(errs() == 3'b001, "R10 fetch error", errs(), 3'b001);
    @(negedge clk);
    chk(errs() == 0 && !cycO, "R10 back to idle", errs(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_fetch();
    t_load_wait();
    t_store();
    t_priority();
    t_error_attrib();
    t_err_and_ack();
    t_timeout();
    finish_run();
  end
endmodule